// File: doc/BRIEF.md
# Video RAM Block-Transfer DMA Engine

This engine moves data from system memory into an 8 KiB video RAM window, always in whole 16-byte chunks. Software programs a source address, a destination address and a control byte over a byte-wide register bus. The engine then reads system memory through a simple synchronous read port and writes video RAM through a write port, at one byte per clock. The busy output is high while bytes are moving.

There are two modes, chosen by the control byte. In general mode the whole transfer runs at once, with no gaps. In blanking mode exactly one chunk moves each time the horizontal-blank strobe rises. A blanking transfer that is waiting between chunks can be cancelled. Reading the control register returns the number of chunks still owed minus one, or 0xFF when nothing is pending.

The addresses advance as chunks complete. A follow-up transfer therefore continues where the previous one stopped, unless software writes new addresses.

Top module: `vdma_engine`

## Requirements
- R1: The low 4 bits written to the source-low register are ignored. Source reads start on a 16-byte boundary at {source-high, source-low[7:4], 0000}, and the 16-bit source address wraps from 0xFFFF to 0x0000.
- R2: The destination is a 13-bit video RAM offset. It is built as {dest-high[4:0], dest-low[7:4], 0000}, so dest-high bits 7:5 and dest-low bits 3:0 are ignored. The offset wraps from 0x1FFF to 0x0000.
- R3: Writing the control register (sel 4) with bit 7 = 0 starts a general transfer of (bits 6:0 + 1) × 16 bytes. The bytes are copied in address order at one byte per clock. Each video RAM write follows its memory read by one cycle, and busy is high for the whole run.
- R4: After a transfer, the source and destination have each advanced by the number of bytes moved. A new control write with no address writes continues from there.
- R5: reg_rdata is registered and reflects reg_sel from the previous cycle. Selects 0–3 read 0xFF. The control select reads 0xFF when no transfer is pending, and otherwise the remaining chunk count minus one.
- R6: Writing the control register with bit 7 = 1 starts a blanking transfer. No bytes move until the blanking strobe rises. Each rising edge moves exactly one 16-byte chunk, however long the strobe stays high.
- R7: A blanking transfer started while the strobe is already high moves its first chunk without waiting for a new edge.
- R8: A control write with bit 7 = 0 while a blanking transfer is pending cancels it. The status reads 0xFF afterwards, later strobe edges move nothing, and no general transfer is started by that write.
- R9: Every register write made while busy is high is ignored. This covers address registers and the control register.
- R10: After reset, busy and the video RAM write enable are low and the control register reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 src high, 1 src low, 2 dst high, 3 dst low, 4 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered readback of the selected register |
| hblank | input | 1 | Horizontal-blank level, synchronous to clk |
| mem_rd_en | output | 1 | System memory read enable |
| mem_raddr | output | 16 | System memory read address |
| mem_rdata | input | 8 | System memory read data, valid one cycle after the read |
| vram_we | output | 1 | Video RAM write enable |
| vram_waddr | output | 13 | Video RAM write offset |
| vram_wdata | output | 8 | Video RAM write data |
| busy | output | 1 | High while a chunk is being copied |

## Verification
The assertions rely on three properties of the environment. The system memory returns read data exactly one clock after an enabled read. The blanking strobe is already synchronous to clk. No chunk can be cut short, because register writes during busy are dropped. The bench keeps to these rules: its memory model is a single registered read of a computed byte pattern, and it drives the strobe and all register accesses on the falling edge. A monitor follows every video RAM write against an independently advanced source pointer and destination pointer. The directed cases deliberately write registers while busy, hold the strobe high across several chunks' worth of cycles, and cancel between chunks.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  typedef enum logic [2:0] {
    SEL_SRC_HI = 3'd0,
    SEL_SRC_LO = 3'd1,
    SEL_DST_HI = 3'd2,
    SEL_DST_LO = 3'd3,
    SEL_CTRL   = 3'd4
  } reg_sel_e;

  localparam logic [7:0] STATUS_NONE = 8'hFF;
endpackage

// File: rtl/vdma_regs.sv
// Address registers: hold chunk-aligned source and destination, advance per chunk.
module vdma_regs import vdma_pkg::*; #(
  parameter int ADDR_W   = 16,
  parameter int VRAM_AW  = 13,
  parameter int CHUNK_LG = 4,
  localparam int SRC_BW  = ADDR_W - CHUNK_LG,
  localparam int DST_BW  = VRAM_AW - CHUNK_LG,
  localparam int LO_BITS = 8 - CHUNK_LG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [2:0]        sel,
  input  logic [7:0]        wdata,
  input  logic              busy,
  input  logic              chunk_done,
  output logic [SRC_BW-1:0] src_blk,
  output logic [DST_BW-1:0] dst_blk,
  output logic              ctrl_wr,
  output logic [7:0]        ctrl_val
);
  logic wr_ok;
  assign wr_ok    = wr && !busy;
  assign ctrl_wr  = wr_ok && (sel == SEL_CTRL);
  assign ctrl_val = wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_blk <= '0;
      dst_blk <= '0;
    end else if (chunk_done) begin
      src_blk <= src_blk + 1'b1;
      dst_blk <= dst_blk + 1'b1;
    end else if (wr_ok) begin
      case (sel)
        SEL_SRC_HI: src_blk[SRC_BW-1:LO_BITS] <= wdata[ADDR_W-9:0];
        SEL_SRC_LO: src_blk[LO_BITS-1:0]      <= wdata[7:CHUNK_LG];
        SEL_DST_HI: dst_blk[DST_BW-1:LO_BITS] <= wdata[VRAM_AW-9:0];
        SEL_DST_LO: dst_blk[LO_BITS-1:0]      <= wdata[7:CHUNK_LG];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vdma_seq.sv
// Chunk sequencer: length, mode, blanking edge trigger, cancel, byte index.
module vdma_seq #(
  parameter int CHUNK_LG = 4,
  parameter int LEN_W    = 7,
  localparam int CNT_W   = LEN_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctrl_wr,
  input  logic [7:0]          ctrl_val,
  input  logic                hblank,
  output logic                busy,
  output logic [CHUNK_LG-1:0] byte_idx,
  output logic                chunk_done,
  output logic [7:0]          status
);
  logic [CNT_W-1:0] remain;
  logic             hb_mode;
  logic             hb_prev;
  logic             trig;
  logic             pending;

  assign pending    = (remain != '0);
  assign chunk_done = busy && (&byte_idx);
  assign status     = pending ? 8'(remain - 1'b1) : 8'hFF;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain   <= '0;
      hb_mode  <= 1'b0;
      hb_prev  <= 1'b0;
      trig     <= 1'b0;
      busy     <= 1'b0;
      byte_idx <= '0;
    end else begin
      hb_prev <= hblank;
      if (hblank && !hb_prev && hb_mode && pending)
        trig <= 1'b1;
      if (ctrl_wr) begin
        if (ctrl_val[7]) begin
          hb_mode  <= 1'b1;
          remain   <= {1'b0, ctrl_val[LEN_W-1:0]} + 1'b1;
          trig     <= hblank;
          byte_idx <= '0;
        end else if (hb_mode && pending) begin
          remain  <= '0;
          hb_mode <= 1'b0;
          trig    <= 1'b0;
        end else begin
          hb_mode  <= 1'b0;
          remain   <= {1'b0, ctrl_val[LEN_W-1:0]} + 1'b1;
          trig     <= 1'b0;
          busy     <= 1'b1;
          byte_idx <= '0;
        end
      end else if (busy) begin
        byte_idx <= byte_idx + 1'b1;
        if (chunk_done) begin
          remain <= remain - 1'b1;
          if (hb_mode || remain == CNT_W'(1))
            busy <= 1'b0;
        end
      end else if (trig && pending) begin
        busy <= 1'b1;
        trig <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vdma_out.sv
// Registered output stage: video RAM write strobe/address and register readback.
module vdma_out import vdma_pkg::*; #(
  parameter int VRAM_AW  = 13,
  parameter int CHUNK_LG = 4,
  localparam int DST_BW  = VRAM_AW - CHUNK_LG
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [DST_BW-1:0]   dst_blk,
  input  logic [CHUNK_LG-1:0] byte_idx,
  input  logic [2:0]          sel,
  input  logic [7:0]          status,
  output logic                vram_we,
  output logic [VRAM_AW-1:0]  vram_waddr,
  output logic [7:0]          reg_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vram_we    <= 1'b0;
      vram_waddr <= '0;
      reg_rdata  <= STATUS_NONE;
    end else begin
      vram_we    <= rd_en;
      vram_waddr <= {dst_blk, byte_idx};
      reg_rdata  <= (sel == SEL_CTRL) ? status : STATUS_NONE;
    end
  end
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine #(
  parameter int ADDR_W   = 16,
  parameter int VRAM_AW  = 13,
  parameter int CHUNK_LG = 4,
  parameter int LEN_W    = 7,
  localparam int SRC_BW  = ADDR_W - CHUNK_LG,
  localparam int DST_BW  = VRAM_AW - CHUNK_LG
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [2:0]         reg_sel,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               hblank,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_raddr,
  input  logic [7:0]         mem_rdata,
  output logic               vram_we,
  output logic [VRAM_AW-1:0] vram_waddr,
  output logic [7:0]         vram_wdata,
  output logic               busy
);
  logic [SRC_BW-1:0]   src_blk;
  logic [DST_BW-1:0]   dst_blk;
  logic                ctrl_wr;
  logic [7:0]          ctrl_val;
  logic [CHUNK_LG-1:0] byte_idx;
  logic                chunk_done;
  logic [7:0]          status;

  vdma_regs #(.ADDR_W(ADDR_W), .VRAM_AW(VRAM_AW), .CHUNK_LG(CHUNK_LG)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .busy(busy), .chunk_done(chunk_done), .src_blk(src_blk), .dst_blk(dst_blk),
    .ctrl_wr(ctrl_wr), .ctrl_val(ctrl_val)
  );

  vdma_seq #(.CHUNK_LG(CHUNK_LG), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_val(ctrl_val), .hblank(hblank),
    .busy(busy), .byte_idx(byte_idx), .chunk_done(chunk_done), .status(status)
  );

  vdma_out #(.VRAM_AW(VRAM_AW), .CHUNK_LG(CHUNK_LG)) u_out (
    .clk(clk), .rst(rst), .rd_en(mem_rd_en), .dst_blk(dst_blk), .byte_idx(byte_idx),
    .sel(reg_sel), .status(status), .vram_we(vram_we), .vram_waddr(vram_waddr),
    .reg_rdata(reg_rdata)
  );

  assign mem_rd_en  = busy;
  assign mem_raddr  = {src_blk, byte_idx};
  assign vram_wdata = mem_rdata;
endmodule

// File: rtl/vdma_engine_chk.sv
module vdma_engine_chk #(
  parameter int ADDR_W   = 16,
  parameter int VRAM_AW  = 13,
  parameter int CHUNK_LG = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         reg_sel,
  input logic [7:0]         reg_rdata,
  input logic               mem_rd_en,
  input logic [ADDR_W-1:0]  mem_raddr,
  input logic               vram_we,
  input logic [VRAM_AW-1:0] vram_waddr,
  input logic               busy
);
  AST_CHUNK_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (mem_raddr[CHUNK_LG-1:0] == '0)); // R1

  AST_RADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en) && mem_raddr[CHUNK_LG-1:0] != '0)
      |-> (mem_raddr == ADDR_W'($past(mem_raddr) + 1'b1))); // R3

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> vram_we); // R3

  AST_WADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (vram_we && $past(vram_we) && vram_waddr[CHUNK_LG-1:0] != '0)
      |-> (vram_waddr == VRAM_AW'($past(vram_waddr) + 1'b1))); // R2

  AST_WHOLE_CHUNK: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(mem_raddr[CHUNK_LG-1:0]) == '1)); // R9

  AST_UNSEL_READ: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_sel) != 3'd4) |-> (reg_rdata == 8'hFF)); // R5
endmodule

bind vdma_engine vdma_engine_chk #(.ADDR_W(ADDR_W), .VRAM_AW(VRAM_AW), .CHUNK_LG(CHUNK_LG)) u_chk (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
  .mem_rd_en(mem_rd_en), .mem_raddr(mem_raddr), .vram_we(vram_we),
  .vram_waddr(vram_waddr), .busy(busy)
);

// File: tb/vdma_engine_bench.sv
`timescale 1ns/1ps
module vdma_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        hblank = 1'b0;
  logic        mem_rd_en;
  logic [15:0] mem_raddr;
  logic [7:0]  mem_rdata = 8'h00;
  logic        vram_we;
  logic [12:0] vram_waddr;
  logic [7:0]  vram_wdata;
  logic        busy;

  int tests = 0;
  int fails = 0;
  int wr_count = 0;
  logic [15:0] exp_src = '0;
  logic [12:0] exp_dst = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vdma_engine u_vdma_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .hblank(hblank), .mem_rd_en(mem_rd_en), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .vram_we(vram_we), .vram_waddr(vram_waddr),
    .vram_wdata(vram_wdata), .busy(busy)
  );

  function automatic logic [7:0] pattern(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= pattern(mem_raddr);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Byte-by-byte monitor: order, destination offset and data (R1, R2, R3)
  always @(negedge clk) begin
    if (!rst && vram_we) begin
      check(vram_waddr == exp_dst, "R2 write offset", vram_waddr, exp_dst);
      check(vram_wdata == pattern(exp_src), "R1 write data", vram_wdata, pattern(exp_src));
      exp_src  = exp_src + 16'd1;
      exp_dst  = exp_dst + 13'd1;
      wr_count = wr_count + 1;
    end
  end

  task automatic wr_reg(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk);
    reg_sel = s;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    idle_cycles(3);
    while (busy) @(negedge clk);
    idle_cycles(3);
  endtask

  task automatic program_addr(input logic [7:0] sh, input logic [7:0] sl,
                              input logic [7:0] dh, input logic [7:0] dl);
    wr_reg(3'd0, sh); wr_reg(3'd1, sl); wr_reg(3'd2, dh); wr_reg(3'd3, dl);
    exp_src = {sh, sl & 8'hF0};
    exp_dst = {dh[4:0], dl & 8'hF0};
  endtask

  task automatic pulse_hblank();
    @(negedge clk); hblank = 1'b1;
    idle_cycles(3);
    hblank = 1'b0;
    idle_cycles(30);
  endtask

  // {src_hi, src_lo, dst_hi, dst_lo, ctrl}
  localparam logic [39:0] VECS [4] = '{
    40'h12_3F_E0_05_00,
    40'hC4_A7_FF_F9_01,
    40'h00_0F_35_48_03,
    40'hFF_F0_09_11_02
  };

  initial begin
    logic [7:0] rv;
    idle_cycles(5);
    rst = 1'b0;
    idle_cycles(1);
    check(busy == 1'b0, "R10 busy after reset", busy, 0);
    check(vram_we == 1'b0, "R10 write enable after reset", vram_we, 0);
    rd_reg(3'd4, rv);
    check(rv == 8'hFF, "R10 status after reset", rv, 8'hFF);
    rd_reg(3'd0, rv);
    check(rv == 8'hFF, "R5 unselected read", rv, 8'hFF);

    // General-mode vectors (R1, R2, R3)
    for (int i = 0; i < 4; i++) begin
      program_addr(VECS[i][39:32], VECS[i][31:24], VECS[i][23:16], VECS[i][15:8]);
      wr_count = 0;
      wr_reg(3'd4, VECS[i][7:0]);
      idle_cycles(2);
      check(busy == 1'b1, "R3 busy during copy", busy, 1);
      wait_idle();
      check(wr_count == (int'(VECS[i][6:0]) + 1) * 16, "R3 byte count", wr_count,
            (int'(VECS[i][6:0]) + 1) * 16);
      rd_reg(3'd4, rv);
      check(rv == 8'hFF, "R5 status after general", rv, 8'hFF);
    end

    // R4: continue without reprogramming
    wr_count = 0;
    wr_reg(3'd4, 8'h00);
    wait_idle();
    check(wr_count == 16, "R4 continued transfer", wr_count, 16);

    // R6: blanking mode, one chunk per rising edge
    program_addr(8'h40, 8'h00, 8'h02, 8'h00);
    wr_count = 0;
    wr_reg(3'd4, 8'h82);
    idle_cycles(30);
    check(wr_count == 0, "R6 no copy before edge", wr_count, 0);
    rd_reg(3'd4, rv);
    check(rv == 8'h02, "R5 pending status", rv, 8'h02);
    pulse_hblank();
    check(wr_count == 16, "R6 first edge", wr_count, 16);
    rd_reg(3'd4, rv);
    check(rv == 8'h01, "R5 status after one chunk", rv, 8'h01);
    @(negedge clk); hblank = 1'b1;
    idle_cycles(60);
    check(wr_count == 32, "R6 long strobe moves one chunk", wr_count, 32);
    hblank = 1'b0;
    idle_cycles(5);
    pulse_hblank();
    check(wr_count == 48, "R6 final chunk", wr_count, 48);
    rd_reg(3'd4, rv);
    check(rv == 8'hFF, "R6 status when complete", rv, 8'hFF);

    // R7: start while strobe already high
    @(negedge clk); hblank = 1'b1;
    program_addr(8'h55, 8'h5A, 8'h0A, 8'hB3);
    wr_count = 0;
    wr_reg(3'd4, 8'h81);
    idle_cycles(30);
    check(wr_count == 16, "R7 immediate first chunk", wr_count, 16);
    idle_cycles(30);
    check(wr_count == 16, "R7 no second chunk without edge", wr_count, 16);
    hblank = 1'b0;
    idle_cycles(3);

    // R8: cancel pending blanking transfer
    wr_reg(3'd4, 8'h00);
    idle_cycles(20);
    check(wr_count == 16, "R8 cancel starts no copy", wr_count, 16);
    rd_reg(3'd4, rv);
    check(rv == 8'hFF, "R8 status after cancel", rv, 8'hFF);
    pulse_hblank();
    check(wr_count == 16, "R8 edge after cancel", wr_count, 16);

    // R9: writes during busy are ignored
    program_addr(8'h60, 8'h00, 8'h00, 8'h00);
    wr_count = 0;
    wr_reg(3'd4, 8'h03);
    idle_cycles(2);
    wr_reg(3'd0, 8'h77);
    wr_reg(3'd2, 8'h10);
    wr_reg(3'd4, 8'h05);
    wait_idle();
    idle_cycles(20);
    check(wr_count == 64, "R9 control write while busy", wr_count, 64);
    wr_reg(3'd4, 8'h00);
    wait_idle();
    check(wr_count == 80, "R9 addresses kept", wr_count, 80);
    check(exp_src == 16'h6050, "R9 source continuity", exp_src, 16'h6050);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule